// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block holds a 32-bit word of pending interrupt causes and turns changes in that word into an interrupt towards the host. Two single-cycle event inputs each set a fixed bit of the word. One reports that a compute job has finished, the other that a DMA transfer has finished. Software can also set any bits by writing a mask to a raise register, and it clears bits by writing a mask to an acknowledge register. The status word itself can be read back through the same register port.

The interrupt leaves the block in one of two forms, chosen by a mode input. In line mode a registered level goes high when a raise leaves the word nonzero. It drops when an acknowledge empties the word. In message mode every raise that leaves the word nonzero emits a one-cycle request strobe, and that includes a raise whose mask is zero. An acknowledge in message mode produces no output activity at all. The block that formats the actual message on the bus consumes the strobe.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status word is zero, `irq_level` is low and `msi_req` is low.
- R2: A pulse on `ev_compute_done` sets status bit 0 and a pulse on `ev_dma_done` sets status bit 8, one clock after the pulse is sampled.
- R3: A write to offset 0x60 ORs `wr_data` into the status word.
- R4: A write to offset 0x64 clears every status bit that is 1 in `wr_data` and leaves the other bits unchanged.
- R5: When a hardware event and an acknowledge target the same bit in one cycle, the bit ends up set.
- R6: `rd_data` shows the current status word when `rd_addr` is 0x24 and all ones for any other `rd_addr`.
- R7: With `msi_en` low, a raise (an event pulse or a write to 0x60) that leaves the status nonzero drives `irq_level` high on the next clock.
- R8: With `msi_en` low, an acknowledge that leaves the status zero drives `irq_level` low on the next clock, and an acknowledge that leaves it nonzero keeps the level.
- R9: With `msi_en` high, each cycle containing a raise that leaves the status nonzero produces `msi_req` high for exactly the following cycle, and `irq_level` does not change.
- R10: With `msi_en` high, an acknowledge produces no `msi_req` and does not change `irq_level`.
- R11: `msi_req` is never high except in the cycle after a message-mode raise that left the status nonzero.
- R12: Writes to offsets other than 0x60 and 0x64, including 0x24, leave the status word and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| ev_compute_done | input | 1 | Compute-done event pulse (status bit 0) |
| ev_dma_done | input | 1 | DMA-done event pulse (status bit 8) |
| msi_en | input | 1 | 1 selects message mode, 0 selects line mode |
| irq_level | output | 1 | Level-sensitive interrupt line |
| msi_req | output | 1 | One-cycle message interrupt request |

## Verification
A corrupted status bit appears on `rd_data` in the very next cycle that reads offset 0x24. It also shows up one clock later as a wrong line level or a missing or extra request strobe, because both outputs are computed from the next status value. A line level that is stuck or dropped at the wrong time shows up on `irq_level` one clock after the raise or acknowledge that should have moved it. A wrong strobe shows as a pulse without a matching raise, or as a raise with no pulse. The sweep keeps a model of the word and of the level, and it compares all outputs every cycle, so any divergence is caught in the cycle after it occurs.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned STATUS_W = 32;
  localparam int unsigned NUM_SRC  = 2;

  typedef logic [STATUS_W-1:0] status_t;

  // Next value of the word: requested sets win over requested clears.
  function automatic status_t f_update(status_t cur, status_t set_m, status_t clr_m);
    return (cur & ~clr_m) | set_m;
  endfunction

  function automatic logic f_nonzero(status_t v);
    return |v;
  endfunction

  // Map a vector of event pulses onto their status bit positions.
  function automatic status_t f_spread(logic [NUM_SRC-1:0] ev,
                                       int unsigned pos0, int unsigned pos1);
    status_t m;
    m = '0;
    if (ev[0]) m[pos0] = 1'b1;
    if (ev[1]) m[pos1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_RAISE  = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_ACK    = 8'h64
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  status_t           wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  status_t           status_q,
  output logic              raise_wr,
  output logic              ack_wr,
  output status_t           sw_set,
  output status_t           sw_clr,
  output status_t           rd_data
);

  localparam status_t ALL_ONES = '1;

  assign raise_wr = wr_en && (wr_addr == OFS_RAISE);
  assign ack_wr   = wr_en && (wr_addr == OFS_ACK);
  assign sw_set   = raise_wr ? wr_data : '0;
  assign sw_clr   = ack_wr   ? wr_data : '0;

  always_comb begin
    if (rd_addr == OFS_STATUS) rd_data = status_q;
    else                       rd_data = ALL_ONES;
  end

endmodule

// File: rtl/irq_agg_srcmap.sv
module irq_agg_srcmap
  import irq_agg_pkg::*;
#(
  parameter int unsigned BIT_COMPUTE = 0,
  parameter int unsigned BIT_DMA     = 8
) (
  input  logic [NUM_SRC-1:0] ev_in,
  output status_t            hw_set,
  output logic               hw_any
);

  assign hw_set = f_spread(ev_in, BIT_COMPUTE, BIT_DMA);
  assign hw_any = |ev_in;

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
  import irq_agg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  status_t set_mask,
  input  status_t clr_mask,
  output status_t status_q,
  output status_t status_nx
);

  assign status_nx = f_update(status_q, set_mask, clr_mask);

  for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= status_nx[b];
    end
  end

endmodule

// File: rtl/irq_agg_signal.sv
module irq_agg_signal
  import irq_agg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    raise_evt,
  input  logic    ack_evt,
  input  logic    msi_en,
  input  status_t status_nx,
  output logic    irq_level,
  output logic    msi_req
);

  logic nx_nz;
  assign nx_nz = f_nonzero(status_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
      msi_req   <= 1'b0;
    end else begin
      msi_req <= raise_evt && nx_nz && msi_en;
      if (!msi_en) begin
        if (raise_evt && nx_nz)      irq_level <= 1'b1;
        else if (ack_evt && !nx_nz)  irq_level <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h24,
  parameter logic [ADDR_W-1:0] OFS_RAISE  = 8'h60,
  parameter logic [ADDR_W-1:0] OFS_ACK    = 8'h64,
  parameter int unsigned BIT_COMPUTE = 0,
  parameter int unsigned BIT_DMA     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [STATUS_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [STATUS_W-1:0] rd_data,
  input  logic                ev_compute_done,
  input  logic                ev_dma_done,
  input  logic                msi_en,
  output logic                irq_level,
  output logic                msi_req
);

  // Named internal events, visible to the bound checker.
  logic    raise_wr, ack_wr, hw_any;
  logic    raise_evt, ack_evt;
  status_t sw_set, sw_clr, hw_set;
  status_t set_mask, clr_mask;
  status_t status_q, status_nx;

  irq_agg_regif #(
    .ADDR_W(ADDR_W), .OFS_STATUS(OFS_STATUS),
    .OFS_RAISE(OFS_RAISE), .OFS_ACK(OFS_ACK)
  ) u_regif (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .status_q(status_q),
    .raise_wr(raise_wr), .ack_wr(ack_wr),
    .sw_set(sw_set), .sw_clr(sw_clr), .rd_data(rd_data)
  );

  irq_agg_srcmap #(
    .BIT_COMPUTE(BIT_COMPUTE), .BIT_DMA(BIT_DMA)
  ) u_srcmap (
    .ev_in({ev_dma_done, ev_compute_done}),
    .hw_set(hw_set), .hw_any(hw_any)
  );

  assign set_mask  = hw_set | sw_set;
  assign clr_mask  = sw_clr;
  assign raise_evt = hw_any | raise_wr;
  assign ack_evt   = ack_wr;

  irq_agg_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask),
    .status_q(status_q), .status_nx(status_nx)
  );

  irq_agg_signal u_signal (
    .clk(clk), .rst_n(rst_n),
    .raise_evt(raise_evt), .ack_evt(ack_evt), .msi_en(msi_en),
    .status_nx(status_nx),
    .irq_level(irq_level), .msi_req(msi_req)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    msi_en,
  input logic    irq_level,
  input logic    msi_req,
  input logic    raise_evt,
  input logic    ack_evt,
  input status_t set_mask,
  input status_t clr_mask,
  input status_t status_q,
  input status_t status_nx
);

  // R1: first cycle out of reset is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (status_q == '0 && !irq_level && !msi_req));

  // R3 / R2: requested set bits are present one clock later
  p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((status_q & $past(set_mask)) == $past(set_mask)));

  // R4 / R5: cleared bits without a concurrent set are gone one clock later
  p_clear_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0) |=> ((status_q & $past(clr_mask & ~set_mask)) == '0));

  // R7: line rises only after a line-mode raise
  p_line_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_level) |-> $past(raise_evt && !msi_en));

  // R8: line falls only after a line-mode acknowledge that emptied the word
  p_line_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_level) |-> ($past(ack_evt && !msi_en) && status_q == '0));

  // R10 / R9: message mode never moves the line
  p_line_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |=> $stable(irq_level));

  // R11: every strobe has a message-mode raise with nonzero result behind it
  p_msi_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(raise_evt && msi_en && (status_nx != '0)));

  // R9: a qualifying raise always produces the strobe
  p_msi_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_evt && msi_en && (status_nx != '0)) |=> msi_req);

endmodule

bind irq_status_agg irq_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msi_en(msi_en),
  .irq_level(irq_level), .msi_req(msi_req),
  .raise_evt(raise_evt), .ack_evt(ack_evt),
  .set_mask(set_mask), .clr_mask(clr_mask),
  .status_q(status_q), .status_nx(status_nx)
);

// File: tb/sim_irq_status_agg.sv
module sim_irq_status_agg;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h24;
  localparam logic [7:0] A_RAISE = 8'h60;
  localparam logic [7:0] A_ACK = 8'h64;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [7:0] wr_addr;
  logic [31:0] wr_data;
  logic [7:0] rd_addr;
  logic [31:0] rd_data;
  logic ev_compute_done, ev_dma_done, msi_en;
  logic irq_level, msi_req;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0] m_stat;
  logic m_lvl;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_compute_done(ev_compute_done), .ev_dma_done(ev_dma_done),
    .msi_en(msi_en), .irq_level(irq_level), .msi_req(msi_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Drive one cycle of stimulus, advance the model, check after the edge.
  task automatic cyc(input logic ce, input logic de, input logic we,
                     input logic [7:0] wa, input logic [31:0] wd,
                     input logic [7:0] ra, input logic msi);
    logic [31:0] setm, clrm, nx;
    logic raise, ack, exp_req;
    string st_tag, lv_tag, rq_tag;
    ev_compute_done = ce; ev_dma_done = de;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; msi_en = msi;
    raise = ce | de | (we && wa == A_RAISE);
    ack   = we && wa == A_ACK;
    setm  = {23'd0, de, 7'd0, ce} | ((we && wa == A_RAISE) ? wd : 32'd0);
    clrm  = ack ? wd : 32'd0;
    // bitwise: bit kept if set requested, else old bit unless cleared
    nx = 32'd0;
    for (int b = 0; b < 32; b++)
      nx[b] = setm[b] ? 1'b1 : (clrm[b] ? 1'b0 : m_stat[b]);
    exp_req = msi && raise && (nx != 32'd0);
    if (!msi) begin
      if (raise && nx != 0)      m_lvl = 1'b1;
      else if (ack && nx == 0)   m_lvl = 1'b0;
    end
    m_stat = nx;
    if ((ce | de) && ack && ((clrm & {23'd0, de, 7'd0, ce}) != 0)) st_tag = "R5";
    else if (ack)                                   st_tag = "R4";
    else if (we && wa == A_RAISE)                   st_tag = "R3";
    else if (ce | de)                               st_tag = "R2";
    else                                            st_tag = "R12";
    lv_tag = msi ? "R10" : (ack ? "R8" : "R7");
    rq_tag = msi ? "R9" : "R11";
    @(negedge clk);
    if (ra == A_STAT) chk(st_tag, rd_data, m_stat);
    else              chk("R6", rd_data, 32'hFFFF_FFFF);
    chk(lv_tag, {31'd0, irq_level}, {31'd0, m_lvl});
    chk(rq_tag, {31'd0, msi_req}, {31'd0, exp_req});
  endtask

  task automatic idle(input logic msi);
    cyc(1'b0, 1'b0, 1'b0, 8'h00, 32'd0, A_STAT, msi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = A_STAT;
    ev_compute_done = 0; ev_dma_done = 0; msi_en = 0;
    m_stat = 0; m_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    chk("R1", rd_data, 32'd0);
    chk("R1", {31'd0, irq_level}, 32'd0);
    chk("R1", {31'd0, msi_req}, 32'd0);

    // Line mode directed
    cyc(1, 0, 0, 0, 0, A_STAT, 0);               // R2 compute bit 0, R7 level up
    cyc(0, 1, 0, 0, 0, A_STAT, 0);               // R2 dma bit 8
    cyc(0, 0, 1, A_STAT, 32'hFFFF_FFFF, A_STAT, 0); // R12 write to status ignored
    cyc(0, 0, 1, 8'h20, 32'h0000_00F0, 8'h20, 0);   // R12, R6
    cyc(0, 0, 1, A_ACK, 32'h0000_0001, A_STAT, 0);  // R8 partial ack keeps level
    cyc(0, 1, 1, A_ACK, 32'h0000_0100, A_STAT, 0);  // R5 set beats clear
    cyc(0, 0, 1, A_ACK, 32'hFFFF_FFFF, A_STAT, 0);  // R8 empties, level low
    cyc(0, 0, 1, A_RAISE, 32'd0, A_STAT, 0);        // R7 raise of zero on empty word
    cyc(0, 0, 1, A_RAISE, 32'h8000_0002, A_STAT, 0);// R3
    idle(0);
    // Message mode directed
    cyc(0, 0, 1, A_RAISE, 32'h0000_0010, A_STAT, 1); // R9 pulse, level stays
    idle(1);                                         // R9 pulse lasts one cycle
    cyc(0, 0, 1, A_RAISE, 32'd0, A_STAT, 1);         // R9 zero raise, word nonzero
    cyc(0, 0, 1, A_ACK, 32'hFFFF_FFFF, A_STAT, 1);   // R10 no pulse, level held
    cyc(0, 0, 1, A_RAISE, 32'd0, A_STAT, 1);         // R11 zero raise on empty word
    cyc(1, 1, 0, 0, 0, A_STAT, 1);                   // R9
    cyc(1, 0, 0, 0, 0, A_STAT, 1);                   // R9 back-to-back raise
    cyc(0, 0, 1, A_ACK, 32'hFFFF_FFFF, A_STAT, 0);   // R8 level drops in line mode

    // Sweep
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r1, r2;
      logic [7:0] wa, ra;
      logic [31:0] wd;
      rng = next_rng(rng); r1 = rng;
      rng = next_rng(rng); r2 = rng;
      case (r1[2:0])
        3'd0, 3'd1: wa = A_RAISE;
        3'd2, 3'd3: wa = A_ACK;
        3'd4:       wa = A_STAT;
        default:    wa = r1[15:8];
      endcase
      case (r1[18:17])
        2'd0:    wd = 32'hFFFF_FFFF;
        2'd1:    wd = 32'd0;
        2'd2:    wd = 32'd1 << r2[4:0];
        default: wd = r2 & 32'h0000_0101;
      endcase
      ra = (r1[21:20] == 2'd0) ? r2[31:24] : A_STAT;
      cyc(r1[24] & r1[25], r1[26] & r1[27], r1[28], wa, wd, ra, r1[30]);
    end

    idle(0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule